// File: doc/BRIEF.md
# UART FIFO Interrupt Status Logic

This block turns the fill levels of a UART's receive and transmit FIFOs into two latched raw interrupt flags, one for receive and one for transmit. It also holds a two-bit enable mask and drives the masked flags and a single combined interrupt line. The FIFOs, the serial datapath and the register decode live elsewhere. They deliver the current levels, pop and push pulses, trigger-level selections, a FIFO-enable control and write-one-to-clear strobes.

With FIFOs enabled, a flag sets when its FIFO level crosses the programmed trigger level in the direction that needs service. The receive flag watches for the level rising to the trigger. The transmit flag watches for the level falling to it. A flag clears when FIFO activity moves the level back past the trigger, or when software clears it. The block detects crossings by comparing each level with the level it registered on the previous cycle. A software clear therefore stays in effect while the level sits at the trigger. With FIFOs disabled, each FIFO acts as one holding location. The receive flag follows that location filling, and the transmit flag follows it emptying. In this mode a single pop or push clears the flag.

Top module: `uart_irq_status`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it, `raw_stat`, `masked_stat`, `mask` and `irq` are all zero. Bit 0 of each two-bit vector is receive and bit 1 is transmit.
- R2: The trigger select codes 0, 1, 2, 3 and 4 pick DEPTH/8, DEPTH/4, DEPTH/2, 3*DEPTH/4 and 7*DEPTH/8 entries. With DEPTH = 16 these are 2, 4, 8, 12 and 14. Codes 5 to 7 pick DEPTH/2.
- R3: With `fifo_en` high, the receive flag sets at the edge where `rx_level` is at or above the receive trigger and the level registered at the previous edge was below it.
- R4: With `fifo_en` high, the receive flag clears at any edge where `rx_level` is below the receive trigger.
- R5: With `fifo_en` high, the transmit flag sets at the edge where `tx_level` is at or below the transmit trigger and the previously registered level was above it.
- R6: With `fifo_en` high, the transmit flag clears at any edge where `tx_level` is above the transmit trigger.
- R7: A high `rx_w1c` or `tx_w1c` clears its flag at that edge. A flag that was cleared this way does not set again while the level stays unchanged at or past the trigger.
- R8: When a set condition and a write-one-to-clear occur at the same edge, the flag is set.
- R9: With `fifo_en` low, the receive flag sets when `rx_level` goes from zero to non-zero, and clears on an `rx_pop` pulse.
- R10: With `fifo_en` low, the transmit flag sets when `tx_level` goes from non-zero to zero, and clears on a `tx_push` pulse.
- R11: `mask` loads `mask_wdata` when `mask_we` is high. At every edge, `masked_stat` becomes the new flags AND the new mask, and `irq` becomes the OR of the new `masked_stat`.
- R12: With `fifo_en` high, `rx_pop` and `tx_push` have no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1: FIFO mode; 0: single-location mode |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_trig_sel | input | 3 | Receive trigger select code |
| tx_trig_sel | input | 3 | Transmit trigger select code |
| rx_pop | input | 1 | Receive FIFO read pulse |
| tx_push | input | 1 | Transmit FIFO write pulse |
| rx_w1c | input | 1 | Write-one-to-clear strobe for the receive flag |
| tx_w1c | input | 1 | Write-one-to-clear strobe for the transmit flag |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 2 | Mask write data |
| mask | output | 2 | Current mask |
| raw_stat | output | 2 | Raw flags |
| masked_stat | output | 2 | Flags AND mask |
| irq | output | 1 | OR of masked flags |

## Verification
Receive levels are ramped up to the full depth and back down to zero under every trigger code. Transmit levels are ramped the other way. These ramps show whether each flag sets only at the crossing and clears on the far side, and whether each code decodes to the right count. Clear strobes are given while the level is held at the trigger, and again at the crossing edge itself. This separates level-based setting from edge-based setting and confirms that the set beats the clear. Single-location sequences with pops and pushes are run in both modes, to show whether those pulses clear the flags only when FIFOs are disabled. A long stretch of random levels, strobes and mask writes then mixes all of these cases.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [2:0] {
    TRIG_EIGHTH   = 3'd0,
    TRIG_QUARTER  = 3'd1,
    TRIG_HALF     = 3'd2,
    TRIG_3QUARTER = 3'd3,
    TRIG_7EIGHTHS = 3'd4
  } trig_code_e;

  localparam int unsigned CH_RX = 0;
  localparam int unsigned CH_TX = 1;
  localparam int unsigned N_CH  = 2;
endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [2:0]       sel,
  output logic [LVL_W-1:0] thresh
);
  import uart_irq_pkg::*;

  localparam logic [LVL_W-1:0] T_E  = LVL_W'(DEPTH / 8);
  localparam logic [LVL_W-1:0] T_Q  = LVL_W'(DEPTH / 4);
  localparam logic [LVL_W-1:0] T_H  = LVL_W'(DEPTH / 2);
  localparam logic [LVL_W-1:0] T_3Q = LVL_W'((DEPTH * 3) / 4);
  localparam logic [LVL_W-1:0] T_7E = LVL_W'((DEPTH * 7) / 8);

  always_comb begin
    case (sel)
      TRIG_EIGHTH:   thresh = T_E;
      TRIG_QUARTER:  thresh = T_Q;
      TRIG_HALF:     thresh = T_H;
      TRIG_3QUARTER: thresh = T_3Q;
      TRIG_7EIGHTHS: thresh = T_7E;
      default:       thresh = T_H;
    endcase
  end
endmodule

// File: rtl/uart_irq_flag.sv
module uart_irq_flag #(
  parameter int unsigned LVL_W = 5,
  parameter bit          IS_TX = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thresh,
  input  logic             act,
  input  logic             w1c,
  output logic             flag_nx,
  output logic             flag_q
);
  logic [LVL_W-1:0] prev_q;
  logic set_fifo, clr_fifo, set_single, set_ev, clr_ev;

  generate
    if (IS_TX) begin : g_tx
      // transmit: service is needed when the level drains
      assign set_fifo   = (prev_q > thresh) && (level <= thresh);
      assign clr_fifo   = level > thresh;
      assign set_single = (prev_q != '0) && (level == '0);
    end else begin : g_rx
      // receive: service is needed when the level fills
      assign set_fifo   = (prev_q < thresh) && (level >= thresh);
      assign clr_fifo   = level < thresh;
      assign set_single = (prev_q == '0) && (level != '0);
    end
  endgenerate

  assign set_ev = fifo_en ? set_fifo : set_single;
  assign clr_ev = (fifo_en ? clr_fifo : act) || w1c;

  always_comb begin
    if (set_ev)      flag_nx = 1'b1;
    else if (clr_ev) flag_nx = 1'b0;
    else             flag_nx = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= level;
      flag_q <= flag_nx;
    end
  end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [2:0]       rx_trig_sel,
  input  logic [2:0]       tx_trig_sel,
  input  logic             rx_pop,
  input  logic             tx_push,
  input  logic             rx_w1c,
  input  logic             tx_w1c,
  input  logic             mask_we,
  input  logic [1:0]       mask_wdata,
  output logic [1:0]       mask,
  output logic [1:0]       raw_stat,
  output logic [1:0]       masked_stat,
  output logic             irq
);
  import uart_irq_pkg::*;

  logic [LVL_W-1:0] lvl   [N_CH];
  logic [2:0]       sel   [N_CH];
  logic [LVL_W-1:0] thr   [N_CH];
  logic [N_CH-1:0]  act, w1c, flag_nx, flag_q;
  logic [N_CH-1:0]  mask_nx, masked_nx;

  assign lvl[CH_RX] = rx_level;
  assign lvl[CH_TX] = tx_level;
  assign sel[CH_RX] = rx_trig_sel;
  assign sel[CH_TX] = tx_trig_sel;
  assign act        = {tx_push, rx_pop};
  assign w1c        = {tx_w1c, rx_w1c};

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      uart_irq_trig #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_trig (
        .sel    (sel[c]),
        .thresh (thr[c])
      );
      uart_irq_flag #(.LVL_W(LVL_W), .IS_TX(c == CH_TX)) u_flag (
        .clk     (clk),
        .rst     (rst),
        .fifo_en (fifo_en),
        .level   (lvl[c]),
        .thresh  (thr[c]),
        .act     (act[c]),
        .w1c     (w1c[c]),
        .flag_nx (flag_nx[c]),
        .flag_q  (flag_q[c])
      );
    end
  endgenerate

  assign mask_nx   = mask_we ? mask_wdata : mask;
  assign masked_nx = flag_nx & mask_nx;
  assign raw_stat  = flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask        <= '0;
      masked_stat <= '0;
      irq         <= 1'b0;
    end else begin
      mask        <= mask_nx;
      masked_stat <= masked_nx;
      irq         <= |masked_nx;
    end
  end
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_en,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] tx_level,
  input logic [2:0]       rx_trig_sel,
  input logic [2:0]       tx_trig_sel,
  input logic             rx_pop,
  input logic             tx_push,
  input logic             rx_w1c,
  input logic             tx_w1c,
  input logic             mask_we,
  input logic [1:0]       mask_wdata,
  input logic [1:0]       mask,
  input logic [1:0]       raw_stat,
  input logic [1:0]       masked_stat,
  input logic             irq
);
  function automatic int unsigned level_for(input logic [2:0] s);
    int unsigned fr8;
    fr8 = (s == 3'd0) ? 1 : (s == 3'd1) ? 2 : (s == 3'd3) ? 6 : (s == 3'd4) ? 7 : 4;
    return (DEPTH * fr8) / 8;
  endfunction

  int unsigned rth, tth;
  assign rth = level_for(rx_trig_sel);
  assign tth = level_for(tx_trig_sel);

  p_reset_r1: assert property (@(posedge clk) rst |=> (raw_stat == 2'b00 && mask == 2'b00 && !irq));

  p_rx_set_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_en && !$past(rst) && rx_level >= rth && $past(rx_level) < rth |=> raw_stat[0]);

  p_rx_clr_r4: assert property (@(posedge clk) disable iff (rst)
    fifo_en && rx_level < rth |=> !raw_stat[0]);

  p_tx_set_r5: assert property (@(posedge clk) disable iff (rst)
    fifo_en && !$past(rst) && tx_level <= tth && $past(tx_level) > tth |=> raw_stat[1]);

  p_tx_clr_r6: assert property (@(posedge clk) disable iff (rst)
    fifo_en && tx_level > tth |=> !raw_stat[1]);

  p_w1c_hold_r7: assert property (@(posedge clk) disable iff (rst)
    rx_w1c && !$past(rst) && rx_level == $past(rx_level) |=> !raw_stat[0]);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    tx_w1c && fifo_en && !$past(rst) && tx_level <= tth && $past(tx_level) > tth |=> raw_stat[1]);

  p_rx_single_r9: assert property (@(posedge clk) disable iff (rst)
    !fifo_en && rx_pop && !$past(rst) && rx_level == $past(rx_level) |=> !raw_stat[0]);

  p_tx_single_r10: assert property (@(posedge clk) disable iff (rst)
    !fifo_en && !$past(rst) && tx_level == '0 && $past(tx_level) != '0 |=> raw_stat[1]);

  p_masked_r11: assert property (@(posedge clk) disable iff (rst)
    masked_stat == (raw_stat & mask) && irq == (|masked_stat));

  p_pop_ignored_r12: assert property (@(posedge clk) disable iff (rst)
    fifo_en && rx_pop && !rx_w1c && raw_stat[0] && rx_level >= rth |=> raw_stat[0]);
endmodule

bind uart_irq_status uart_irq_status_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_uart_irq_status.sv
module tb_uart_irq_status;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 1'b1;
  logic [LVL_W-1:0] rx_level = '0, tx_level = '0;
  logic [2:0] rx_trig_sel = 3'd0, tx_trig_sel = 3'd0;
  logic rx_pop = 0, tx_push = 0, rx_w1c = 0, tx_w1c = 0, mask_we = 0;
  logic [1:0] mask_wdata = 2'b00;
  logic [1:0] mask, raw_stat, masked_stat;
  logic irq;

  always #2 clk = ~clk;

  uart_irq_status #(.DEPTH(DEPTH)) dut (.*);

  int checks = 0, errors = 0;
  string req = "R1";

  // behavioural reference model
  int m_prev[2];
  bit m_flag[2];
  bit [1:0] m_mask;

  function automatic int thr(input int s);
    case (s)
      0: return 2;
      1: return 4;
      2: return 8;
      3: return 12;
      4: return 14;
      default: return 8;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_prev[0] = 0; m_prev[1] = 0;
      m_flag[0] = 0; m_flag[1] = 0;
      m_mask = 2'b00;
    end else begin
      int rl, tl, rt, tt;
      bit s, c;
      rl = rx_level; tl = tx_level; rt = thr(rx_trig_sel); tt = thr(tx_trig_sel);
      if (fifo_en) begin s = (m_prev[0] < rt) && (rl >= rt); c = rl < rt; end
      else begin s = (m_prev[0] == 0) && (rl != 0); c = rx_pop; end
      m_flag[0] = s ? 1'b1 : ((c || rx_w1c) ? 1'b0 : m_flag[0]);
      if (fifo_en) begin s = (m_prev[1] > tt) && (tl <= tt); c = tl > tt; end
      else begin s = (m_prev[1] != 0) && (tl == 0); c = tx_push; end
      m_flag[1] = s ? 1'b1 : ((c || tx_w1c) ? 1'b0 : m_flag[1]);
      m_prev[0] = rl; m_prev[1] = tl;
      if (mask_we) m_mask = mask_wdata;
    end
  end

  task automatic cyc();
    bit [1:0] er, em;
    @(posedge clk);
    @(negedge clk);
    er = {m_flag[1], m_flag[0]};
    em = er & m_mask;
    checks++;
    if (raw_stat !== er || mask !== m_mask || masked_stat !== em || irq !== (|em)) begin
      errors++;
      $display("FAIL %s: raw=%b mask=%b masked=%b irq=%b expected raw=%b mask=%b masked=%b irq=%b",
               req, raw_stat, mask, masked_stat, irq, er, m_mask, em, |em);
    end
    rx_pop = 0; tx_push = 0; rx_w1c = 0; tx_w1c = 0; mask_we = 0;
  endtask

  task automatic set_mask(input bit [1:0] m);
    mask_we = 1; mask_wdata = m; cyc();
  endtask

  initial begin
    repeat (3) cyc();          // R1: reset values
    rst = 0;
    req = "R1"; cyc();
    req = "R11"; set_mask(2'b11);

    // R2 R3 R4: receive ramps for every trigger code
    for (int s = 0; s < 8; s++) begin
      rx_trig_sel = 3'(s); req = (s > 4) ? "R2" : "R3";
      for (int l = 0; l <= DEPTH; l++) begin rx_level = LVL_W'(l); cyc(); end
      req = "R4";
      for (int l = DEPTH; l >= 0; l--) begin rx_level = LVL_W'(l); cyc(); end
    end
    // R2 R5 R6: transmit ramps
    tx_level = LVL_W'(DEPTH); cyc();
    for (int s = 0; s < 8; s++) begin
      tx_trig_sel = 3'(s); req = "R5";
      for (int l = DEPTH; l >= 0; l--) begin tx_level = LVL_W'(l); cyc(); end
      req = "R6";
      for (int l = 0; l <= DEPTH; l++) begin tx_level = LVL_W'(l); cyc(); end
    end

    // R7: clear while level held at trigger
    req = "R7"; rx_trig_sel = 3'd2; rx_level = 8; cyc();
    rx_w1c = 1; cyc();
    repeat (4) cyc();
    // R8: clear strobe on crossing edge
    req = "R8"; tx_trig_sel = 3'd1; tx_level = 5; cyc();
    tx_level = 4; tx_w1c = 1; cyc(); cyc();
    // R12: pops and pushes ignored in FIFO mode
    req = "R12"; rx_level = 8; rx_pop = 1; cyc(); rx_pop = 1; cyc();
    tx_push = 1; cyc();

    // R9 R10: single-location mode
    fifo_en = 0; rx_level = 0; tx_level = 1; cyc();
    req = "R9"; rx_level = 1; cyc(); cyc();
    rx_pop = 1; cyc(); rx_level = 0; cyc(); rx_level = 1; cyc();
    rx_w1c = 1; cyc();
    req = "R10"; tx_level = 0; cyc(); cyc();
    tx_push = 1; tx_level = 1; cyc(); tx_level = 0; cyc();
    tx_w1c = 1; cyc();

    // R11: mask patterns
    req = "R11";
    for (int m = 0; m < 4; m++) begin
      rx_level = 1; tx_level = 0; set_mask(2'(m)); cyc();
    end

    // mixed random stretch
    req = "R3..R12 mix";
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 50) == 0) fifo_en = ~fifo_en;
      if (($urandom % 40) == 0) rx_trig_sel = 3'($urandom % 8);
      if (($urandom % 40) == 0) tx_trig_sel = 3'($urandom % 8);
      if (fifo_en) begin
        rx_level = LVL_W'($urandom % (DEPTH + 1));
        tx_level = LVL_W'($urandom % (DEPTH + 1));
      end else begin
        rx_level = LVL_W'($urandom % 2);
        tx_level = LVL_W'($urandom % 2);
      end
      rx_pop  = ($urandom % 4) == 0;
      tx_push = ($urandom % 4) == 0;
      rx_w1c  = ($urandom % 8) == 0;
      tx_w1c  = ($urandom % 8) == 0;
      mask_we = ($urandom % 16) == 0;
      mask_wdata = 2'($urandom % 4);
      cyc();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule